// File: doc/BRIEF.md
# Wide Store Beat Sequencer

This block turns one decoded store instruction into a series of 32-bit write beats on a narrow memory port. It is meant for a core whose registers and data bus are 32 bits wide. Such a core still has to execute doubleword (64-bit) and quadword (128-bit) stores. The block accepts one request at a time: an opcode, an effective address and the source register value. It checks that the address is aligned for the store size. It then drives the memory port one beat per handshake and reports either a retire or an address-error-on-store fault together with the faulting address.

Wide stores place the register value in the lowest beat and zero in every higher beat, because each register holds only 32 bits. Doubleword and quadword stores share one small beat counter, and they differ only in the index of their last beat. Word and halfword stores go through the same path as single-beat stores, so the alignment check for every store size sits in one place.

Top module: `wide_store_seq`

## Requirements
- R1: Opcode 6'h3F (doubleword) with a legal address issues exactly 2 beats: address ea carrying req_rt, then address ea+4 carrying 0.
- R2: Opcode 6'h1F (quadword) with a legal address issues exactly 4 beats at ea, ea+4, ea+8 and ea+12, carrying req_rt on the first beat and 0 on the other three.
- R3: Opcode 6'h2B (word) and opcode 6'h29 (halfword) each issue one beat carrying req_rt at the address ea with bits [1:0] cleared.
- R4: A store is misaligned when ea[3:0]!=0 for a quadword, ea[2:0]!=0 for a doubleword, ea[1:0]!=0 for a word, or ea[0]!=0 for a halfword. For a misaligned store, fault is high in the same cycle the request is presented while the block is idle, fault_addr equals req_ea, and no beat and no retire follow.
- R5: A beat completes only in a cycle where both mem_wr_valid and mem_wr_ready are high. While mem_wr_ready is low, mem_wr_addr and mem_wr_data hold their values.
- R6: retire is high for exactly one cycle per accepted legal store, namely the cycle in which its final beat completes. busy is low in the cycle that follows.
- R7: A request presented while busy is high, or a request with any opcode other than the four above, has no effect: it causes no fault, no beat and no retire.
- R8: After reset the block is idle: busy, mem_wr_valid and retire are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A decoded store request is presented |
| req_op | input | 6 | Primary opcode of the store |
| req_ea | input | 32 | Effective address |
| req_rt | input | 32 | Source register value |
| busy | output | 1 | A store is in flight; new requests are not taken |
| mem_wr_valid | output | 1 | A write beat is offered |
| mem_wr_addr | output | 32 | Byte address of the current beat |
| mem_wr_data | output | 32 | Data of the current beat |
| mem_wr_ready | input | 1 | Memory takes the offered beat |
| retire | output | 1 | The final beat of the store completes this cycle |
| fault | output | 1 | Address-error-on-store for the presented request |
| fault_addr | output | 32 | Faulting effective address, valid with fault |

## Verification
Two events can land in the same cycle: the retire of the final beat, and a new request that is already held on the request port while busy is still high. The bench keeps a second, misaligned request asserted through the whole doubleword sequence, including the retire cycle, and drops it in the idle cycle that follows, before the next clock edge. It then judges the result in two places. The memory model must show no write from that request. The fault and retire counts must show exactly one outcome per accepted store. Throughout the run, mem_wr_ready follows a fixed stall pattern, so many final beats complete only after one or more stalled cycles.

// File: rtl/wide_store_pkg.sv
package wide_store_pkg;

  // Primary opcodes of the stores handled here
  localparam logic [5:0] OPC_STORE_HALF  = 6'h29;
  localparam logic [5:0] OPC_STORE_WORD  = 6'h2B;
  localparam logic [5:0] OPC_STORE_QUAD  = 6'h1F;
  localparam logic [5:0] OPC_STORE_DOUBL = 6'h3F;

  // Widest store issues this many beats; counter sized from it
  localparam int MAX_BEATS = 4;
  localparam int BEAT_W    = $clog2(MAX_BEATS);

  typedef enum logic [1:0] {
    SK_HALF  = 2'd0,
    SK_WORD  = 2'd1,
    SK_DOUBL = 2'd2,
    SK_QUAD  = 2'd3
  } store_kind_e;

  // Index of the last beat for a given store size
  function automatic logic [BEAT_W-1:0] last_beat_of(store_kind_e k);
    case (k)
      SK_QUAD:  last_beat_of = BEAT_W'(3);
      SK_DOUBL: last_beat_of = BEAT_W'(1);
      default:  last_beat_of = '0;
    endcase
  endfunction

  // Low address bits that must be zero for a given store size
  function automatic logic [3:0] align_mask_of(store_kind_e k);
    case (k)
      SK_QUAD:  align_mask_of = 4'b1111;
      SK_DOUBL: align_mask_of = 4'b0111;
      SK_WORD:  align_mask_of = 4'b0011;
      default:  align_mask_of = 4'b0001;
    endcase
  endfunction

endpackage

// File: rtl/store_class_decode.sv
module store_class_decode
  import wide_store_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [5:0]        op,
  input  logic [AW-1:0]     ea,
  output logic              known,
  output logic              misalign,
  output logic [BEAT_W-1:0] last_beat,
  output logic [AW-1:0]     base
);

  store_kind_e kind;

  always_comb begin
    known = 1'b1;
    kind  = SK_WORD;
    case (op)
      OPC_STORE_HALF:  kind = SK_HALF;
      OPC_STORE_WORD:  kind = SK_WORD;
      OPC_STORE_DOUBL: kind = SK_DOUBL;
      OPC_STORE_QUAD:  kind = SK_QUAD;
      default:         known = 1'b0;
    endcase
  end

  always_comb begin
    misalign  = known && ((ea[3:0] & align_mask_of(kind)) != 4'b0000);
    last_beat = last_beat_of(kind);
    // beats always land on word boundaries
    base      = {ea[AW-1:2], 2'b00};
  end

endmodule

// File: rtl/store_beat_ctrl.sv
module store_beat_ctrl
  import wide_store_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BEAT_W-1:0] last_in,
  input  logic              wr_ready,
  output logic              active,
  output logic [BEAT_W-1:0] beat,
  output logic              retire
);

  logic              act_q, act_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [BEAT_W-1:0] last_q, last_d;
  logic              upd_en;

  // next-state process
  always_comb begin
    act_d  = act_q;
    beat_d = beat_q;
    last_d = last_q;
    if (!act_q) begin
      if (start) begin
        act_d  = 1'b1;
        beat_d = '0;
        last_d = last_in;
      end
    end else if (wr_ready) begin
      if (beat_q == last_q) begin
        act_d = 1'b0;
      end else begin
        beat_d = beat_q + BEAT_W'(1);
      end
    end
  end

  assign upd_en = (!act_q && start) || (act_q && wr_ready);

  // register process with clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      beat_q <= '0;
      last_q <= '0;
    end else if (upd_en) begin
      act_q  <= act_d;
      beat_q <= beat_d;
      last_q <= last_d;
    end
  end

  assign active = act_q;
  assign beat   = beat_q;
  assign retire = act_q && wr_ready && (beat_q == last_q);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !wr_ready) |=> (act_q && beat_q == $past(beat_q)));

  // R6
  retire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !act_q);

  // R2
  beat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (beat_q <= last_q));

endmodule

// File: rtl/store_beat_path.sv
module store_beat_path
  import wide_store_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [AW-1:0]     base_in,
  input  logic [DW-1:0]     rt_in,
  input  logic [BEAT_W-1:0] beat,
  output logic [AW-1:0]     addr,
  output logic [DW-1:0]     data
);

  localparam int PAD_W = AW - BEAT_W - 2;

  logic [AW-1:0] base_q;
  logic [DW-1:0] rt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      rt_q   <= '0;
    end else if (load) begin
      base_q <= base_in;
      rt_q   <= rt_in;
    end
  end

  always_comb begin
    addr = base_q + {{PAD_W{1'b0}}, beat, 2'b00};
    // upper lanes carry zero: a register holds only DW bits
    data = (beat == '0) ? rt_q : '0;
  end

endmodule

// File: rtl/wide_store_seq.sv
module wide_store_seq
  import wide_store_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [5:0]    req_op,
  input  logic [AW-1:0] req_ea,
  input  logic [DW-1:0] req_rt,
  output logic          busy,
  output logic          mem_wr_valid,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  input  logic          mem_wr_ready,
  output logic          retire,
  output logic          fault,
  output logic [AW-1:0] fault_addr
);

  logic              dec_known, dec_misalign;
  logic [BEAT_W-1:0] dec_last, cur_beat;
  logic [AW-1:0]     dec_base;
  logic              active, take, launch;

  store_class_decode #(.AW(AW)) u_dec (
    .op        (req_op),
    .ea        (req_ea),
    .known     (dec_known),
    .misalign  (dec_misalign),
    .last_beat (dec_last),
    .base      (dec_base)
  );

  assign take   = req_valid && !active && dec_known;
  assign launch = take && !dec_misalign;

  store_beat_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (launch),
    .last_in  (dec_last),
    .wr_ready (mem_wr_ready),
    .active   (active),
    .beat     (cur_beat),
    .retire   (retire)
  );

  store_beat_path #(.AW(AW), .DW(DW)) u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (launch),
    .base_in (dec_base),
    .rt_in   (req_rt),
    .beat    (cur_beat),
    .addr    (mem_wr_addr),
    .data    (mem_wr_data)
  );

  assign busy         = active;
  assign mem_wr_valid = active;
  assign fault        = take && dec_misalign;
  assign fault_addr   = req_ea;

  // R4
  fault_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !mem_wr_valid);

  // R1
  first_beat_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_valid) |-> (mem_wr_addr == $past(dec_base)
                             && mem_wr_data == $past(req_rt)));

  // R2
  later_beat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && $past(mem_wr_valid && mem_wr_ready)) |-> (mem_wr_data == '0));

  // R7
  busy_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fault);

endmodule

// File: tb/sim_wide_store_seq.sv
module sim_wide_store_seq;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [5:0]  req_op;
  logic [31:0] req_ea, req_rt;
  logic        busy, mem_wr_valid, mem_wr_ready, retire, fault;
  logic [31:0] mem_wr_addr, mem_wr_data, fault_addr;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int n_beats, n_ret, n_flt;
  bit mon_on = 0;
  logic [31:0] mem [MEM_WORDS];
  logic [31:0] exp_mem [MEM_WORDS];
  logic        prev_stall;
  logic [31:0] prev_addr, prev_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_store_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_ea(req_ea), .req_rt(req_rt), .busy(busy),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready),
    .retire(retire), .fault(fault), .fault_addr(fault_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model: drive ready after each falling edge, then sample what the
  // next rising edge will see.
  always @(negedge clk) begin
    cyc++;
    mem_wr_ready = !((cyc % 5 == 2) || (cyc % 7 == 3));
    #1;
    if (mon_on) begin
      if (prev_stall && mem_wr_valid)
        chk(mem_wr_addr == prev_addr && mem_wr_data == prev_data,
            "R5 stall hold", mem_wr_addr, prev_addr);
      if (retire)
        chk(mem_wr_valid && mem_wr_ready, "R6 retire on handshake",
            {31'd0, mem_wr_ready}, 32'd1);
      if (mem_wr_valid && mem_wr_ready) begin
        n_beats++;
        if (mem_wr_addr < 32'(MEM_WORDS*4)) mem[mem_wr_addr[7:2]] = mem_wr_data;
      end
      if (retire) n_ret++;
      if (fault)  n_flt++;
      prev_stall = mem_wr_valid && !mem_wr_ready;
      prev_addr  = mem_wr_addr;
      prev_data  = mem_wr_data;
    end
  end

  initial begin
    #(CLK_PERIOD*100000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic run_store(input logic [5:0] op, input logic [31:0] ea,
                           input logic [31:0] rt, input bit hold_junk);
    int nb; bit known, exp_flt; logic [3:0] msk; logic [31:0] base;
    int mism;
    string tag;
    case (op)
      6'h3F: begin nb = 2; msk = 4'h7; known = 1; tag = "R1"; end
      6'h1F: begin nb = 4; msk = 4'hF; known = 1; tag = "R2"; end
      6'h2B: begin nb = 1; msk = 4'h3; known = 1; tag = "R3"; end
      6'h29: begin nb = 1; msk = 4'h1; known = 1; tag = "R3"; end
      default: begin nb = 0; msk = 4'h0; known = 0; tag = "R7"; end
    endcase
    exp_flt = known && ((ea[3:0] & msk) != 0);
    for (int i = 0; i < MEM_WORDS; i++) begin
      mem[i] = 32'hA5A5_0000 | 32'(i);
      exp_mem[i] = mem[i];
    end
    base = {ea[31:2], 2'b00};
    if (known && !exp_flt)
      for (int b = 0; b < nb; b++)
        exp_mem[(base >> 2) + 32'(b)] = (b == 0) ? rt : 32'd0;
    n_beats = 0; n_ret = 0; n_flt = 0; prev_stall = 0;
    @(negedge clk);
    req_valid = 1; req_op = op; req_ea = ea; req_rt = rt;
    #2;
    chk(fault == exp_flt, "R4 fault same cycle", {31'd0, fault}, {31'd0, exp_flt});
    if (exp_flt) chk(fault_addr == ea, "R4 fault address", fault_addr, ea);
    @(negedge clk);
    if (hold_junk) begin
      // misaligned word store held while busy, through the retire cycle
      req_op = 6'h2B; req_ea = 32'h0000_00F1; req_rt = 32'hBAD0_BAD0;
      while (busy) @(negedge clk);
    end
    req_valid = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    #2;
    chk(n_beats == ((known && !exp_flt) ? nb : 0), {tag, " beat count"},
        32'(n_beats), 32'(nb));
    chk(n_ret == ((known && !exp_flt) ? 1 : 0), "R6 one retire",
        32'(n_ret), 32'((known && !exp_flt) ? 1 : 0));
    chk(n_flt == (exp_flt ? 1 : 0), "R7 no extra fault", 32'(n_flt),
        32'(exp_flt ? 1 : 0));
    mism = 0;
    for (int i = 0; i < MEM_WORDS; i++) if (mem[i] !== exp_mem[i]) mism++;
    chk(mism == 0, {tag, " memory image"}, 32'(mism), 32'd0);
  endtask

  initial begin
    logic [5:0] ops [5];
    ops[0] = 6'h3F; ops[1] = 6'h1F; ops[2] = 6'h2B; ops[3] = 6'h29; ops[4] = 6'h00;
    rst_n = 0; req_valid = 0; req_op = '0; req_ea = '0; req_rt = '0;
    mem_wr_ready = 1;
    repeat (3) @(negedge clk);
    #2;
    // R8
    chk(!busy && !mem_wr_valid && !retire, "R8 reset idle",
        {29'd0, busy, mem_wr_valid, retire}, 32'd0);
    @(negedge clk);
    rst_n = 1;
    mon_on = 1;
    for (int o = 0; o < 5; o++)
      for (int lo = 0; lo < 16; lo++)
        run_store(ops[o], 32'h0000_0080 + 32'(lo),
                  32'h1357_0000 ^ (32'(o) << 12) ^ 32'(lo * 97), 1'b0);
    // R7: request held while busy must be ignored (doubleword, quadword)
    run_store(6'h3F, 32'h0000_0090, 32'hABCD_1234, 1'b1);
    run_store(6'h1F, 32'h0000_00A0, 32'h0F0F_5A5A, 1'b1);
    // R1: doubleword leaves V at A and 0 at A+4
    run_store(6'h3F, 32'h0000_00C8, 32'hFFFF_FFFF, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule